// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an asynchronous 16-bit static RAM. The RAM has two chip selects of opposite polarity, per-byte lane selects, a write strobe and an output enable. The host makes a single-cycle request that carries a direction flag, a word address, write data and a byte-lane mask. The controller then plays out one full memory cycle on the RAM pins. When the cycle is finished it pulses an acknowledge, and for reads it returns the captured word.

Every minimum interval is a parameter counted in clock cycles: address setup before the strobe, strobe width, write recovery, read window and bus turnaround. The pins are ordered so that address, chip select and lane selects are only allowed to move while the write strobe is inactive. The controller's own data drivers are enabled only inside the write strobe and its recovery, and only when the RAM's output enable has been inactive on the previous cycle as well. A change of direction between two transfers inserts a deselected turnaround gap, which gives the RAM time to release the bus. The byte mask applies in both directions: lanes left out of a write are not strobed, and lanes left out of a read come back as zero.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is held, and after reset is released, the RAM side is idle: `mem_cs_n_o`=1, `mem_cs_o`=0, `mem_we_n_o`=1, `mem_oe_n_o`=1, all `mem_bsel_n_o` bits 1 and `mem_dq_oe_o`=0. On the host side `rdy_o`=1 and `ack_o`=0.
- R2: A request is taken on a clock edge where `req_i` and `rdy_o` are both 1. `rdy_o` is 0 from the cycle after that edge until the cycle in which `ack_o` is 1. `ack_o` lasts exactly one cycle, and `rdy_o` is 1 during it.
- R3: A write holds the chip selected with the strobe inactive for T_AS cycles, then holds `mem_we_n_o` low for exactly T_WP cycles, then holds the strobe inactive for T_WR cycles. `ack_o` rises 1+T_AS+T_WP+T_WR cycles after the accepting edge.
- R4: A read holds `mem_oe_n_o` low for T_RC cycles and captures `mem_dq_i` on the last of them. `ack_o` and the new `rdata_o` appear 1+T_RC cycles after the accepting edge.
- R5: On a read, bit b of `req_be_i` (bit 0 is bits 7:0, bit 1 is bits 15:8) drives `mem_bsel_n_o[b]` low. Any lane whose mask bit is 0 returns zero in `rdata_o`.
- R6: On a write, `mem_bsel_n_o[b]` is low only when mask bit b is 1. A write with mask 0 leaves every RAM word unchanged.
- R7: Address, lane selects and chip selects stay constant for as long as `mem_we_n_o` is low.
- R8: `mem_we_n_o` and `mem_oe_n_o` are never low together. The output enable stays high for the whole of a write, and the write strobe stays high for the whole of a read.
- R9: `mem_dq_oe_o` is 1 only while `mem_oe_n_o` is high in both the current cycle and the previous one.
- R10: If an accepted request has the opposite direction from the previous accepted request, T_TA extra deselected cycles come before its memory cycle. Same-direction requests get no gap.
- R11: `req_i` raised while `rdy_o` is 0 is ignored, and no transfer is started from it.
- R12: The `mem_cs_o` and `mem_cs_n_o` selects are active only during the setup, strobe, recovery and read window, and are inactive in idle and turnaround cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request strobe |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte-lane mask, active high |
| rdy_o | output | 1 | Controller can accept a request |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, masked by lane |
| mem_addr_o | output | 17 | RAM address |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_cs_o | output | 1 | Active-high chip select |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_bsel_n_o | output | 2 | Active-low byte-lane selects |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Enable for the data drivers |
| mem_dq_i | input | 16 | Data from the RAM |

## Verification
The hardest case to reach is a request that arrives while a transfer is still running. The busy transfer must be held in a direction change, so that its turnaround gap is part of the wait, and the ignored request must point at a different address with different data. The stimulus keeps `req_i` high with altered fields for several cycles of a write and drops it just before ready returns. It then reads both addresses back through the RAM model: the stray request must have left no trace, and the real write must have landed. The same run checks the cycle count of the busy transfer, which shows that the stray strobe did not stretch or restart it.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_RACC
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (cnt_q != '0);
  assign cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int T_AS  = 1,
  parameter int T_WP  = 5,
  parameter int T_WR  = 2,
  parameter int T_RC  = 7,
  parameter int T_TA  = 3,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic             need_turn_i,
  input  logic             held_we_i,
  input  logic             tmr_zero_i,
  output seq_state_e       state_o,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             accept_o,
  output logic             done_o,
  output logic             capture_o
);

  localparam logic [CNT_W-1:0] AS_LD = CNT_W'(T_AS - 1);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(T_WP - 1);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(T_WR - 1);
  localparam logic [CNT_W-1:0] RC_LD = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] TA_LD = CNT_W'(T_TA - 1);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    accept_o   = 1'b0;
    done_o     = 1'b0;
    capture_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o   = 1'b1;
          tmr_load_o = 1'b1;
          if (need_turn_i) begin
            st_d      = ST_TURN;
            tmr_val_o = TA_LD;
          end else if (req_we_i) begin
            st_d      = ST_WSET;
            tmr_val_o = AS_LD;
          end else begin
            st_d      = ST_RACC;
            tmr_val_o = RC_LD;
          end
        end
      end
      ST_TURN: begin
        if (tmr_zero_i) begin
          tmr_load_o = 1'b1;
          if (held_we_i) begin
            st_d      = ST_WSET;
            tmr_val_o = AS_LD;
          end else begin
            st_d      = ST_RACC;
            tmr_val_o = RC_LD;
          end
        end
      end
      ST_WSET: begin
        if (tmr_zero_i) begin
          st_d       = ST_WPUL;
          tmr_load_o = 1'b1;
          tmr_val_o  = WP_LD;
        end
      end
      ST_WPUL: begin
        if (tmr_zero_i) begin
          st_d       = ST_WREC;
          tmr_load_o = 1'b1;
          tmr_val_o  = WR_LD;
        end
      end
      ST_WREC: begin
        if (tmr_zero_i) begin
          st_d   = ST_IDLE;
          done_o = 1'b1;
        end
      end
      ST_RACC: begin
        if (tmr_zero_i) begin
          st_d      = ST_IDLE;
          done_o    = 1'b1;
          capture_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int NBYTE  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              done_i,
  input  logic              capture_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [NBYTE-1:0]  req_be_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] held_addr_o,
  output logic [DATA_W-1:0] held_wdata_o,
  output logic [NBYTE-1:0]  held_be_o,
  output logic              held_we_o,
  output logic              need_turn_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              have_prev_q;
  logic [DATA_W-1:0] lane_mask;

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{held_be_o[b]}};
  end

  // the held direction is the one of the last accepted request
  assign need_turn_o = have_prev_q & (req_we_i != held_we_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_addr_o  <= '0;
      held_wdata_o <= '0;
      held_be_o    <= '0;
      held_we_o    <= 1'b0;
      have_prev_q  <= 1'b0;
    end else if (accept_i) begin
      held_addr_o  <= req_addr_i;
      held_wdata_o <= req_wdata_i;
      held_be_o    <= req_be_i;
      held_we_o    <= req_we_i;
      have_prev_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_o <= 1'b0;
    end else begin
      ack_o <= done_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o <= '0;
    end else if (capture_i) begin
      rdata_o <= mem_dq_i & lane_mask;
    end
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int T_AS   = 1,
  parameter int T_WP   = 5,
  parameter int T_WR   = 2,
  parameter int T_RC   = 7,
  parameter int T_TA   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic                  req_we_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [DATA_W-1:0]     req_wdata_i,
  input  logic [DATA_W/8-1:0]   req_be_i,
  output logic                  rdy_o,
  output logic                  ack_o,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic                  mem_cs_n_o,
  output logic                  mem_cs_o,
  output logic                  mem_we_n_o,
  output logic                  mem_oe_n_o,
  output logic [DATA_W/8-1:0]   mem_bsel_n_o,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe_o,
  input  logic [DATA_W-1:0]     mem_dq_i
);

  localparam int NBYTE = DATA_W / 8;
  localparam int MAXT  = max_of(max_of(max_of(T_AS, T_WP), max_of(T_WR, T_RC)), T_TA);
  localparam int CNT_W = (MAXT > 1) ? $clog2(MAXT) : 1;

  // reset asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  seq_state_e       state;
  logic             tmr_load, tmr_zero, accept, done, capture;
  logic [CNT_W-1:0] tmr_val;
  logic             held_we, need_turn;
  logic [NBYTE-1:0] held_be;
  logic             active;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  sram_seq_fsm #(
    .T_AS(T_AS), .T_WP(T_WP), .T_WR(T_WR), .T_RC(T_RC), .T_TA(T_TA), .CNT_W(CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_i       (req_i),
    .req_we_i    (req_we_i),
    .need_turn_i (need_turn),
    .held_we_i   (held_we),
    .tmr_zero_i  (tmr_zero),
    .state_o     (state),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .accept_o    (accept),
    .done_o      (done),
    .capture_o   (capture)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTE(NBYTE)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .accept_i     (accept),
    .done_i       (done),
    .capture_i    (capture),
    .req_we_i     (req_we_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_be_i     (req_be_i),
    .mem_dq_i     (mem_dq_i),
    .held_addr_o  (mem_addr_o),
    .held_wdata_o (mem_dq_o),
    .held_be_o    (held_be),
    .held_we_o    (held_we),
    .need_turn_o  (need_turn),
    .ack_o        (ack_o),
    .rdata_o      (rdata_o)
  );

  // pin decode from the registered state
  always_comb begin
    active       = (state == ST_WSET) || (state == ST_WPUL) ||
                   (state == ST_WREC) || (state == ST_RACC);
    rdy_o        = (state == ST_IDLE);
    mem_cs_n_o   = ~active;
    mem_cs_o     = active;
    mem_we_n_o   = (state != ST_WPUL);
    mem_oe_n_o   = (state != ST_RACC);
    mem_bsel_n_o = active ? ~held_be : '1;
    mem_dq_oe_o  = (state == ST_WPUL) || (state == ST_WREC);
  end

endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int NBYTE  = 2,
  parameter int T_WP   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rdy_o,
  input logic              ack_o,
  input logic              mem_cs_n_o,
  input logic              mem_cs_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [NBYTE-1:0]  mem_bsel_n_o,
  input logic              mem_dq_oe_o
);

  logic [15:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (!mem_we_n_o) begin
      low_run_q <= low_run_q + 16'd1;
    end else begin
      low_run_q <= '0;
    end
  end

  // R8
  strobe_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n_o && !mem_oe_n_o));

  // R9
  drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> (mem_oe_n_o && $past(mem_oe_n_o)));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o && !$past(mem_we_n_o)) |->
      ($stable(mem_addr_o) && $stable(mem_bsel_n_o) && $stable(mem_cs_n_o)));

  // R12
  strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n_o || !mem_oe_n_o) |-> (!mem_cs_n_o && mem_cs_o));

  // R2
  ack_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> rdy_o);

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R3
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> (low_run_q == 16'(T_WP)));

endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .ADDR_W(ADDR_W), .NBYTE(DATA_W / 8), .T_WP(T_WP)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rdy_o        (rdy_o),
  .ack_o        (ack_o),
  .mem_cs_n_o   (mem_cs_n_o),
  .mem_cs_o     (mem_cs_o),
  .mem_we_n_o   (mem_we_n_o),
  .mem_oe_n_o   (mem_oe_n_o),
  .mem_addr_o   (mem_addr_o),
  .mem_bsel_n_o (mem_bsel_n_o),
  .mem_dq_oe_o  (mem_dq_oe_o)
);

// File: tb/sram_seq_ctrl_bench.sv
module sram_seq_ctrl_bench;

  localparam int CLK_P = 10;
  localparam int T_AS  = 1;
  localparam int T_WP  = 5;
  localparam int T_WR  = 2;
  localparam int T_RC  = 7;
  localparam int T_TA  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rdy, ack;
  logic [15:0] rdata;
  logic [16:0] m_addr;
  logic        m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe;
  logic [1:0]  m_bsel_n;
  logic [15:0] m_dq_o, m_dq_i;

  int checks = 0;
  int fails  = 0;
  int addr_moves = 0;
  int overlap_bad = 0;
  int drive_bad = 0;
  int pulse_bad = 0;
  int low_run = 0;
  logic        prev_we_n = 1'b1;
  logic        prev_oe_n = 1'b1;
  logic [16:0] prev_addr = '0;

  logic [15:0] model [64];

  always #(CLK_P/2) clk = ~clk;

  sram_seq_ctrl #(
    .T_AS(T_AS), .T_WP(T_WP), .T_WR(T_WR), .T_RC(T_RC), .T_TA(T_TA)
  ) u_sram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rdy_o(rdy), .ack_o(ack), .rdata_o(rdata),
    .mem_addr_o(m_addr), .mem_cs_n_o(m_cs_n), .mem_cs_o(m_cs),
    .mem_we_n_o(m_we_n), .mem_oe_n_o(m_oe_n), .mem_bsel_n_o(m_bsel_n),
    .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe), .mem_dq_i(m_dq_i)
  );

  // RAM model: 64 words, driven only when selected and output enabled
  assign m_dq_i = (!m_cs_n && m_cs && !m_oe_n && m_we_n) ? model[m_addr[5:0]] : 16'hDEAD;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) model[i] <= 16'h0000;
    end else if (!m_we_n && !m_cs_n && m_cs && m_dq_oe) begin
      for (int b = 0; b < 2; b++)
        if (!m_bsel_n[b]) model[m_addr[5:0]][b*8 +: 8] <= m_dq_o[b*8 +: 8];
    end
  end

  // pin-rule monitors, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!m_we_n && !prev_we_n && (m_addr != prev_addr)) addr_moves++;
      if (!m_we_n && !m_oe_n) overlap_bad++;
      if (m_dq_oe && (!m_oe_n || !prev_oe_n)) drive_bad++;
      if (!m_we_n) low_run++;
      else if (low_run != 0) begin
        if (low_run != T_WP) pulse_bad++;
        low_run = 0;
      end
    end
    prev_we_n = m_we_n;
    prev_oe_n = m_oe_n;
    prev_addr = m_addr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic we, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] be, output int cyc, output logic [15:0] rd);
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req = 1'b0;
    cyc = 1;
    chk("R2 ready low after accept", {31'd0, rdy}, 32'd0);
    while (!ack && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    rd = rdata;
    @(negedge clk);
    chk("R2 ack single cycle", {31'd0, ack}, 32'd0);
  endtask

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [15:0] wd;
    logic [1:0]  be;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 17'h00005, 16'hA1B2, 2'b11, 16'h0000},
    '{1'b1, 17'h00009, 16'h1234, 2'b11, 16'h0000},
    '{1'b0, 17'h00005, 16'h0000, 2'b11, 16'hA1B2},
    '{1'b1, 17'h00005, 16'hFFEE, 2'b01, 16'h0000},
    '{1'b0, 17'h00005, 16'h0000, 2'b11, 16'hA1EE},
    '{1'b1, 17'h00009, 16'h5600, 2'b10, 16'h0000},
    '{1'b0, 17'h00009, 16'h0000, 2'b10, 16'h5600},
    '{1'b0, 17'h00009, 16'h0000, 2'b01, 16'h0034},
    '{1'b1, 17'h00003, 16'h7777, 2'b00, 16'h0000},
    '{1'b0, 17'h00003, 16'h0000, 2'b11, 16'h0000}
  };

  initial begin
    int          cyc;
    int          exp_cyc;
    logic [15:0] rd;
    logic        have_prev;
    logic        prev_we;
    have_prev = 1'b0;
    prev_we   = 1'b0;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 idle pins in reset",
        {24'd0, m_cs_n, m_cs, m_we_n, m_oe_n, m_bsel_n, m_dq_oe, rdy},
        {24'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1});
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 after release
    chk("R1 idle pins after reset",
        {23'd0, m_cs_n, m_cs, m_we_n, m_oe_n, m_bsel_n, m_dq_oe, rdy, ack},
        {23'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0});

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].we, VECS[i].addr, VECS[i].wd, VECS[i].be, cyc, rd);
      exp_cyc = 1 + (VECS[i].we ? (T_AS + T_WP + T_WR) : T_RC) +
                ((have_prev && (prev_we != VECS[i].we)) ? T_TA : 0);
      // R3 / R4 / R10: completion latency
      chk(VECS[i].we ? "R3 R10 write latency" : "R4 R10 read latency", cyc, exp_cyc);
      if (!VECS[i].we)
        chk("R4 R5 R6 read data", {16'd0, rd}, {16'd0, VECS[i].exp});
      have_prev = 1'b1;
      prev_we   = VECS[i].we;
    end

    // R11: stray request held high during a busy write
    @(negedge clk);
    while (!rdy) @(negedge clk);
    req = 1'b1; req_we = 1'b1; req_addr = 17'h00007; req_wdata = 16'h1111; req_be = 2'b11;
    @(negedge clk);
    req_addr = 17'h00008; req_wdata = 16'h2222;
    cyc = 1;
    repeat (6) begin
      @(negedge clk);
      cyc++;
    end
    req = 1'b0;
    while (!ack && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk("R11 R10 busy write latency", cyc, 1 + T_TA + T_AS + T_WP + T_WR);
    do_op(1'b0, 17'h00008, 16'h0000, 2'b11, cyc, rd);
    chk("R11 stray request wrote nothing", {16'd0, rd}, 32'd0);
    chk("R10 turnaround before read", cyc, 1 + T_TA + T_RC);
    do_op(1'b0, 17'h00007, 16'h0000, 2'b11, cyc, rd);
    chk("R11 real write landed", {16'd0, rd}, {16'd0, 16'h1111});
    chk("R10 no gap same direction", cyc, 1 + T_RC);

    // R12: deselected once idle again
    chk("R12 deselected when idle", {30'd0, m_cs_n, m_cs}, {30'd0, 1'b1, 1'b0});
    chk("R7 address still under strobe", addr_moves, 0);
    chk("R8 strobe and output enable apart", overlap_bad, 0);
    chk("R9 drivers only with output disabled", drive_bad, 0);
    chk("R3 strobe width", pulse_bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule